// File: doc/BRIEF.md
# Snooping Cache Coherence Controller

This block keeps four private write-back caches coherent over a single shared snooping bus, with a shared next-level store behind that bus. Each core drives a load/store port into its own direct-mapped cache. Each line in that cache holds a coherence state (Invalid, Shared or Exclusive), an address tag, a dirty flag and one block of data. Reads and writes that hit locally finish in one cycle and stay off the bus. Anything else waits for the bus.

A round-robin arbiter gives the bus to one requesting core at a time, and that core's transaction runs to completion before the next grant. A transaction moves through several phases. First comes an optional write-back of a dirty victim. Then a broadcast phase runs, in which every other cache snoops the address, and any Exclusive owner writes its block back to the shared store. Last comes a fill phase, in which the requester installs the block from the shared store. A write always finishes Exclusive. The core's request stays pending, and the core stalls, until the completion pulse.

Top module: `coh_snoop_top`

## Requirements
- R1: After reset every cache line is Invalid, the shared store holds zero in every word, `core_done` is low and `core_rdata` is zero.
- R2: A load to a line that is not present broadcasts a read miss and installs the block Shared. With the bus idle it completes 3 cycles after the request is presented and returns the stored word.
- R3: A store to a line that is not present broadcasts an invalidating write miss, fetches the block, merges the word and installs it Exclusive. Every other copy becomes Invalid. With no victim it takes 3 cycles.
- R4: A store that hits a Shared line broadcasts an invalidate with no fetch and moves the line to Exclusive in 3 cycles.
- R5: A cache that snoops a write miss or an invalidate for a block it holds becomes Invalid for that block. If it held the block Exclusive, it first writes the block back.
- R6: A cache that snoops a read miss for a block it holds Exclusive writes the block back and drops to Shared. The requester then receives the written-back data.
- R7: Load hits on Shared or Exclusive lines, and store hits on Exclusive lines, complete 1 cycle after the request, cause no bus transaction and leave the state unchanged.
- R8: Coherence works on whole blocks. Address bit 0 selects the word within a 2-word block, bits 2:1 select the line and bits 7:3 form the tag. A store to one word invalidates the whole block in other caches, so a later access there to the other word misses.
- R9: A miss whose line slot holds a different block in the Exclusive, dirty state first writes that victim back to the shared store. This adds one cycle, giving a 4-cycle write miss.
- R10: Only one bus transaction is in flight at a time. Grants rotate round-robin, starting at core 0 after reset, and each transaction holds the bus for 3 cycles. A core whose request is pending stalls until its own completion pulse, which lasts one cycle.
- R11: No block is ever held Exclusive by one cache while any other cache holds it in a valid state.
- R12: Every load returns the value of the most recent completed store to that word, in bus order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | NCORE | Per-core request, held until `core_done` |
| core_write | input | NCORE | Per-core 1 = store, 0 = load |
| core_addr | input | NCORE x ADDR_W | Per-core word address |
| core_wdata | input | NCORE x DATA_W | Per-core store data |
| core_done | output | NCORE | One-cycle completion pulse per core |
| core_rdata | output | NCORE x DATA_W | Load data, valid with `core_done` |

## Verification
The hardest case to reach from the ports is a block that changes hands several times. In that case an Exclusive owner has to be forced into a write-back by a snoop, either a read miss from another core or its own eviction. False sharing across the two words of a block must also be exercised. Coherence state cannot be seen directly, so the bench infers it from exact completion latency: 1 cycle means a local hit, 3 means a bus transaction and 4 means a victim write-back. A directed chain walks one block through every transition. A long pseudo-random sweep over sixteen conflicting addresses and all four cores then checks each load against an arithmetic reference store.

// File: rtl/coh_pkg.sv
// Package: shared types for the snooping coherence block.
// Assumes: two-bit state encoding, Invalid is zero so a reset array reads empty.
package coh_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2
    } coh_state_e;

    typedef enum logic [1:0] {
        PH_ARB   = 2'd0,
        PH_VICT  = 2'd1,
        PH_SNOOP = 2'd2,
        PH_FILL  = 2'd3
    } bus_phase_e;
endpackage

// File: rtl/coh_shmem.sv
// Module: shared next-level store, one block per entry.
// Does: one synchronous write port, one combinational block read port.
// Assumes: always ready; contents cleared by reset.
module coh_shmem #(
    parameter int BA_W  = 7,
    parameter int BLK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BA_W-1:0]  wr_baddr,
    input  logic [BLK_W-1:0] wr_block,
    input  logic [BA_W-1:0]  rd_baddr,
    output logic [BLK_W-1:0] rd_block
);
    localparam int DEPTH = 1 << BA_W;

    logic [BLK_W-1:0] mem_q [DEPTH];

    // Purpose: clear on reset, otherwise take one block write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_baddr] <= wr_block;
        end
    end

    // Purpose: combinational block read.
    always_comb rd_block = mem_q[rd_baddr];
endmodule

// File: rtl/coh_rr_arb.sv
// Module: round-robin bus arbiter.
// Does: grants the first requester after the last granted index.
// Assumes: N >= 2; pointer moves only when advance is high and someone requests.
module coh_rr_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx
);
    logic [IW-1:0] last_q;

    // Purpose: scan requesters starting one past the last grant.
    always_comb begin
        logic found;
        grant     = '0;
        grant_idx = '0;
        found     = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int c;
            c = int'(last_q) + off;
            if (c >= N) c = c - N;
            if (!found && req[c]) begin
                found     = 1'b1;
                grant[c]  = 1'b1;
                grant_idx = IW'(c);
            end
        end
    end

    // Purpose: remember the last granted index; reset points at N-1 so core 0 wins first.
    always_ff @(posedge clk) begin
        if (!rst_n)                last_q <= IW'(N - 1);
        else if (advance && |req)  last_q <= grant_idx;
    end

    // R10
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((|req) == (|grant)))
        else $error("arbiter grant malformed");
endmodule

// File: rtl/coh_l1.sv
// Module: one private direct-mapped write-back cache with coherence state.
// Does: serves local hits in one cycle, raises miss_req otherwise, reacts to
//       snoops from the bus and installs fills issued by the bus controller.
// Assumes: core holds its request until core_done; snoop and fill never target
//          this cache in the same cycle; hold blocks local hits while snooping.
module coh_l1
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int LINES = 1 << IDX_W,
    localparam int WORDS = 1 << OFF_W,
    localparam int BLK_W = DATA_W * WORDS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        core_valid,
    input  logic                        core_write,
    input  logic [ADDR_W-1:0]           core_addr,
    input  logic [DATA_W-1:0]           core_wdata,
    output logic                        core_done,
    output logic [DATA_W-1:0]           core_rdata,
    output logic                        miss_req,
    output logic [1:0]                  loc_state,
    output logic [TAG_W-1:0]            loc_tag,
    output logic                        loc_dirty,
    output logic [BLK_W-1:0]            loc_block,
    input  logic                        hold,
    input  logic                        snp_valid,
    input  logic                        snp_inv,
    input  logic [ADDR_W-1:0]           snp_addr,
    output logic                        snp_owner,
    output logic [BLK_W-1:0]            snp_block,
    input  logic                        fill_en,
    input  logic                        fill_excl,
    input  logic [BLK_W-1:0]            fill_block,
    output logic [LINES-1:0][1:0]       line_state,
    output logic [LINES-1:0][TAG_W-1:0] line_tag
);
    coh_state_e       state_q [LINES];
    logic [TAG_W-1:0] tag_q   [LINES];
    logic             dirty_q [LINES];
    logic [BLK_W-1:0] data_q  [LINES];
    logic             done_q;
    logic [DATA_W-1:0] rdata_q;

    logic [IDX_W-1:0] req_idx, snp_idx;
    logic [TAG_W-1:0] req_tag, snp_tag;
    logic [OFF_W-1:0] req_off;
    logic             tag_hit, can_hit, active, do_hit, snp_match;
    logic [BLK_W-1:0] merged_hit, merged_fill, fill_final;

    // Purpose: split request and snoop addresses into tag, index and offset.
    always_comb begin
        req_off = core_addr[OFF_W-1:0];
        req_idx = core_addr[OFF_W +: IDX_W];
        req_tag = core_addr[ADDR_W-1 -: TAG_W];
        snp_idx = snp_addr[OFF_W +: IDX_W];
        snp_tag = snp_addr[ADDR_W-1 -: TAG_W];
    end

    // Purpose: hit classification for the pending core request.
    always_comb begin
        tag_hit  = (state_q[req_idx] != ST_INV) && (tag_q[req_idx] == req_tag);
        can_hit  = tag_hit && ((state_q[req_idx] == ST_EXC) || !core_write);
        active   = core_valid && !done_q;
        do_hit   = active && can_hit && !hold;
        miss_req = active && !can_hit;
    end

    // Purpose: snoop lookup on the broadcast address.
    always_comb begin
        snp_match = snp_valid && (state_q[snp_idx] != ST_INV) && (tag_q[snp_idx] == snp_tag);
        snp_owner = snp_match && (state_q[snp_idx] == ST_EXC);
        snp_block = data_q[snp_idx];
    end

    // Purpose: merge store data into the local line and into an incoming fill.
    always_comb begin
        merged_hit  = data_q[req_idx];
        merged_hit[int'(req_off)*DATA_W +: DATA_W] = core_wdata;
        merged_fill = fill_block;
        merged_fill[int'(req_off)*DATA_W +: DATA_W] = core_wdata;
        fill_final  = core_write ? merged_fill : fill_block;
    end

    // Purpose: expose the line at the request index and the whole state array.
    always_comb begin
        loc_state = state_q[req_idx];
        loc_tag   = tag_q[req_idx];
        loc_dirty = dirty_q[req_idx];
        loc_block = data_q[req_idx];
        for (int l = 0; l < LINES; l++) begin
            line_state[l] = state_q[l];
            line_tag[l]   = tag_q[l];
        end
    end

    // Purpose: line arrays, completion pulse and load data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                state_q[l] <= ST_INV;
                tag_q[l]   <= '0;
                dirty_q[l] <= 1'b0;
                data_q[l]  <= '0;
            end
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (fill_en) begin
                state_q[req_idx] <= fill_excl ? ST_EXC : ST_SHR;
                tag_q[req_idx]   <= req_tag;
                dirty_q[req_idx] <= fill_excl;
                data_q[req_idx]  <= fill_final;
                rdata_q          <= fill_final[int'(req_off)*DATA_W +: DATA_W];
                done_q           <= 1'b1;
            end else if (do_hit) begin
                done_q  <= 1'b1;
                rdata_q <= data_q[req_idx][int'(req_off)*DATA_W +: DATA_W];
                if (core_write) begin
                    data_q[req_idx]  <= merged_hit;
                    dirty_q[req_idx] <= 1'b1;
                    rdata_q          <= core_wdata;
                end
            end
            if (snp_match) begin
                if (snp_inv) begin
                    state_q[snp_idx] <= ST_INV;
                    dirty_q[snp_idx] <= 1'b0;
                end else if (state_q[snp_idx] == ST_EXC) begin
                    state_q[snp_idx] <= ST_SHR;
                    dirty_q[snp_idx] <= 1'b0;
                end
            end
        end
    end

    assign core_done  = done_q;
    assign core_rdata = rdata_q;

    // R2
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> core_done)
        else $error("fill without completion");

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done)
        else $error("completion longer than one cycle");

    // R5
    snp_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_match && snp_inv) |=> (state_q[$past(snp_idx)] == ST_INV))
        else $error("snooped invalidate left line valid");

    // R6
    snp_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_owner && !snp_inv) |=> (state_q[$past(snp_idx)] == ST_SHR))
        else $error("snooped read miss did not downgrade owner");

    // R7
    hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_hit |=> (state_q[$past(req_idx)] == $past(state_q[req_idx])))
        else $error("local hit changed coherence state");
endmodule

// File: rtl/coh_bus_ctrl.sv
// Module: snooping bus sequencer.
// Does: arbitrates misses, writes back a dirty victim, broadcasts the snoop
//       (collecting an owner's write-back) and drives the requester's fill.
// Assumes: cache outputs loc_* reflect the line at each core's own request index.
module coh_bus_ctrl
    import coh_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int BLK_W = DATA_W * (1 << OFF_W),
    localparam int BA_W  = ADDR_W - OFF_W,
    localparam int IW    = $clog2(NCORE)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCORE-1:0]              miss_req,
    input  logic [NCORE-1:0]              core_write,
    input  logic [NCORE-1:0][ADDR_W-1:0]  core_addr,
    input  logic [NCORE-1:0][1:0]         loc_state,
    input  logic [NCORE-1:0][TAG_W-1:0]   loc_tag,
    input  logic [NCORE-1:0]              loc_dirty,
    input  logic [NCORE-1:0][BLK_W-1:0]   loc_block,
    input  logic [NCORE-1:0]              snp_owner,
    input  logic [NCORE-1:0][BLK_W-1:0]   snp_block,
    input  logic [BLK_W-1:0]              mem_rd_block,
    output logic                          hold,
    output logic [NCORE-1:0]              snp_valid,
    output logic                          snp_inv,
    output logic [ADDR_W-1:0]             snp_addr,
    output logic [NCORE-1:0]              fill_en,
    output logic                          fill_excl,
    output logic [BLK_W-1:0]              fill_block,
    output logic                          mem_we,
    output logic [BA_W-1:0]               mem_wr_baddr,
    output logic [BLK_W-1:0]              mem_wr_block,
    output logic [BA_W-1:0]               mem_rd_baddr
);
    bus_phase_e        phase_q;
    logic [IW-1:0]     own_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q, upg_q;

    logic [NCORE-1:0]  grant;
    logic [IW-1:0]     gidx;
    logic [TAG_W-1:0]  g_tag;
    logic              g_upg, g_vict;
    logic [BLK_W-1:0]  owner_blk;

    coh_rr_arb #(.N(NCORE)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (miss_req),
        .advance   (phase_q == PH_ARB),
        .grant     (grant),
        .grant_idx (gidx)
    );

    // Purpose: classify the granted request (upgrade, victim write-back).
    always_comb begin
        g_tag  = core_addr[gidx][ADDR_W-1 -: TAG_W];
        g_upg  = core_write[gidx] && (loc_state[gidx] == ST_SHR) && (loc_tag[gidx] == g_tag);
        g_vict = (loc_state[gidx] == ST_EXC) && loc_dirty[gidx] && (loc_tag[gidx] != g_tag);
    end

    // Purpose: gather the block offered by the single snoop owner.
    always_comb begin
        owner_blk = '0;
        for (int i = 0; i < NCORE; i++)
            if (snp_owner[i]) owner_blk = owner_blk | snp_block[i];
    end

    // Purpose: phase sequencer, one transaction at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ARB;
            own_q   <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            upg_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_ARB: if (|miss_req) begin
                    own_q   <= gidx;
                    addr_q  <= core_addr[gidx];
                    wr_q    <= core_write[gidx];
                    upg_q   <= g_upg;
                    phase_q <= g_vict ? PH_VICT : PH_SNOOP;
                end
                PH_VICT:  phase_q <= PH_SNOOP;
                PH_SNOOP: phase_q <= PH_FILL;
                default:  phase_q <= PH_ARB;
            endcase
        end
    end

    // Purpose: bus, snoop, fill and store drives for the current phase.
    always_comb begin
        hold         = (phase_q == PH_SNOOP);
        snp_inv      = wr_q;
        snp_addr     = addr_q;
        fill_excl    = wr_q;
        fill_block   = upg_q ? loc_block[own_q] : mem_rd_block;
        mem_rd_baddr = addr_q[ADDR_W-1:OFF_W];
        mem_we       = 1'b0;
        mem_wr_baddr = addr_q[ADDR_W-1:OFF_W];
        mem_wr_block = owner_blk;
        for (int i = 0; i < NCORE; i++) begin
            snp_valid[i] = (phase_q == PH_SNOOP) && (IW'(i) != own_q);
            fill_en[i]   = (phase_q == PH_FILL) && (IW'(i) == own_q);
        end
        if (phase_q == PH_VICT) begin
            mem_we       = 1'b1;
            mem_wr_baddr = {loc_tag[own_q], addr_q[OFF_W +: IDX_W]};
            mem_wr_block = loc_block[own_q];
        end else if (phase_q == PH_SNOOP && (|snp_owner)) begin
            mem_we = 1'b1;
        end
    end

    // R11
    owner_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(snp_owner))
        else $error("more than one cache owns a snooped block");

    // R9
    vict_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_VICT) |=> (phase_q == PH_SNOOP) ##1 (|fill_en))
        else $error("victim write-back not followed by snoop then fill");
endmodule

// File: rtl/coh_snoop_top.sv
// Module: top of the snooping coherence block.
// Does: instantiates one private cache per core, the bus sequencer and the
//       shared store, and checks the single-writer rule across caches.
// Assumes: each core holds valid/write/addr/wdata stable until core_done.
module coh_snoop_top
    import coh_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCORE-1:0]             core_valid,
    input  logic [NCORE-1:0]             core_write,
    input  logic [NCORE-1:0][ADDR_W-1:0] core_addr,
    input  logic [NCORE-1:0][DATA_W-1:0] core_wdata,
    output logic [NCORE-1:0]             core_done,
    output logic [NCORE-1:0][DATA_W-1:0] core_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int LINES = 1 << IDX_W;
    localparam int BLK_W = DATA_W * (1 << OFF_W);
    localparam int BA_W  = ADDR_W - OFF_W;

    logic [NCORE-1:0]                  miss_req, loc_dirty, snp_owner, snp_valid, fill_en;
    logic [NCORE-1:0][1:0]             loc_state;
    logic [NCORE-1:0][TAG_W-1:0]       loc_tag;
    logic [NCORE-1:0][BLK_W-1:0]       loc_block, snp_block;
    logic [NCORE-1:0][LINES-1:0][1:0]  all_state;
    logic [NCORE-1:0][LINES-1:0][TAG_W-1:0] all_tag;
    logic                              hold, snp_inv, fill_excl, mem_we;
    logic [ADDR_W-1:0]                 snp_addr;
    logic [BLK_W-1:0]                  fill_block, mem_wr_block, mem_rd_block;
    logic [BA_W-1:0]                   mem_wr_baddr, mem_rd_baddr;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        coh_l1 #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
        ) u_l1 (
            .clk        (clk),
            .rst_n      (rst_n),
            .core_valid (core_valid[c]),
            .core_write (core_write[c]),
            .core_addr  (core_addr[c]),
            .core_wdata (core_wdata[c]),
            .core_done  (core_done[c]),
            .core_rdata (core_rdata[c]),
            .miss_req   (miss_req[c]),
            .loc_state  (loc_state[c]),
            .loc_tag    (loc_tag[c]),
            .loc_dirty  (loc_dirty[c]),
            .loc_block  (loc_block[c]),
            .hold       (hold),
            .snp_valid  (snp_valid[c]),
            .snp_inv    (snp_inv),
            .snp_addr   (snp_addr),
            .snp_owner  (snp_owner[c]),
            .snp_block  (snp_block[c]),
            .fill_en    (fill_en[c]),
            .fill_excl  (fill_excl),
            .fill_block (fill_block),
            .line_state (all_state[c]),
            .line_tag   (all_tag[c])
        );
    end

    coh_bus_ctrl #(
        .NCORE(NCORE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_req     (miss_req),
        .core_write   (core_write),
        .core_addr    (core_addr),
        .loc_state    (loc_state),
        .loc_tag      (loc_tag),
        .loc_dirty    (loc_dirty),
        .loc_block    (loc_block),
        .snp_owner    (snp_owner),
        .snp_block    (snp_block),
        .mem_rd_block (mem_rd_block),
        .hold         (hold),
        .snp_valid    (snp_valid),
        .snp_inv      (snp_inv),
        .snp_addr     (snp_addr),
        .fill_en      (fill_en),
        .fill_excl    (fill_excl),
        .fill_block   (fill_block),
        .mem_we       (mem_we),
        .mem_wr_baddr (mem_wr_baddr),
        .mem_wr_block (mem_wr_block),
        .mem_rd_baddr (mem_rd_baddr)
    );

    coh_shmem #(.BA_W(BA_W), .BLK_W(BLK_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mem_we),
        .wr_baddr (mem_wr_baddr),
        .wr_block (mem_wr_block),
        .rd_baddr (mem_rd_baddr),
        .rd_block (mem_rd_block)
    );

    // Purpose: single-writer check across every pair of caches and every line.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCORE; i++)
                for (int j = 0; j < NCORE; j++)
                    for (int l = 0; l < LINES; l++) begin
                        // R11
                        excl_sole_chk: assert (!((i != j) &&
                            (all_state[i][l] == ST_EXC) &&
                            (all_state[j][l] != ST_INV) &&
                            (all_tag[i][l] == all_tag[j][l])))
                            else $error("block exclusive in one cache and valid in another");
                    end
        end
    end
endmodule

// File: tb/coh_snoop_top_bench.sv
`timescale 1ns/1ps
module coh_snoop_top_bench;
    localparam int NC = 4;
    localparam int AW = 8;
    localparam int DW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NC-1:0]        core_valid = '0;
    logic [NC-1:0]        core_write = '0;
    logic [NC-1:0][AW-1:0] core_addr = '0;
    logic [NC-1:0][DW-1:0] core_wdata = '0;
    logic [NC-1:0]        core_done;
    logic [NC-1:0][DW-1:0] core_rdata;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] ref_mem [256];

    coh_snoop_top u_coh_snoop_top (
        .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_write(core_write),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_done(core_done), .core_rdata(core_rdata)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // One request on one core; returns load data and latency in cycles.
    task automatic do_op(input int c, input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        core_valid[c] = 1'b1; core_write[c] = wr; core_addr[c] = a; core_wdata[c] = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!core_done[c] && lat < 200);
        rd = core_rdata[c];
        core_valid[c] = 1'b0;
        if (wr) ref_mem[a] = d;
    endtask

    task automatic op_chk(input string tag, input int c, input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int exp_lat, input int exp_rd);
        logic [DW-1:0] rd;
        int lat;
        do_op(c, wr, a, d, rd, lat);
        check({tag, " latency"}, lat, exp_lat);
        if (exp_rd >= 0) check({tag, " data"}, int'(rd), exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 done after reset", int'(core_done), 0);
        check("R1 rdata after reset", int'(core_rdata), 0);

        // R10 four simultaneous misses on line 3: round-robin from core 0, 3 cycles each
        fork
            op_chk("R10 rr core0", 0, 1'b0, 8'h06, 16'h0, 3, 0);
            op_chk("R10 rr core1", 1, 1'b0, 8'h0E, 16'h0, 6, 0);
            op_chk("R10 rr core2", 2, 1'b0, 8'h16, 16'h0, 9, 0);
            op_chk("R10 rr core3", 3, 1'b0, 8'h1E, 16'h0, 12, 0);
        join
        // R4 upgrade on core1 moves the pointer to 1
        op_chk("R4 upgrade core1", 1, 1'b1, 8'h0E, 16'h00AA, 3, -1);
        // R10 cores 0 and 2 together: core2 follows core1 in rotation
        fork
            op_chk("R10 rotate core2", 2, 1'b1, 8'h16, 16'h00BB, 3, -1);
            op_chk("R10 rotate core0", 0, 1'b1, 8'h06, 16'h00CC, 6, -1);
        join

        // Directed walk of block 0x10/0x11 (line 0, tag 2)
        op_chk("R2 read miss",        0, 1'b0, 8'h10, 16'h0,    3, 0);
        op_chk("R7 read hit shared",  0, 1'b0, 8'h10, 16'h0,    1, 0);
        op_chk("R2 second sharer",    1, 1'b0, 8'h10, 16'h0,    3, 0);
        op_chk("R4 write hit shared", 0, 1'b1, 8'h10, 16'h1111, 3, -1);
        op_chk("R7 write hit excl",   0, 1'b1, 8'h10, 16'h2222, 1, -1);
        op_chk("R7 read hit excl",    0, 1'b0, 8'h10, 16'h0,    1, 16'h2222);
        op_chk("R5 R6 snoop owner",   1, 1'b0, 8'h10, 16'h0,    3, 16'h2222);
        op_chk("R6 owner now shared", 0, 1'b0, 8'h10, 16'h0,    1, 16'h2222);
        op_chk("R6 upgrade proves S", 0, 1'b1, 8'h10, 16'h3333, 3, -1);
        op_chk("R8 other word miss",  1, 1'b0, 8'h11, 16'h0,    3, 0);
        op_chk("R8 upgrade word 1",   1, 1'b1, 8'h11, 16'h4444, 3, -1);
        op_chk("R8 false sharing",    0, 1'b0, 8'h10, 16'h0,    3, 16'h3333);
        op_chk("R3 write miss",       2, 1'b1, 8'h10, 16'h5555, 3, -1);
        op_chk("R9 victim writeback", 2, 1'b1, 8'h30, 16'h6666, 4, -1);
        op_chk("R9 victim data",      3, 1'b0, 8'h10, 16'h0,    3, 16'h5555);
        op_chk("R9 block word 1",     3, 1'b0, 8'h11, 16'h0,    1, 16'h4444);
        op_chk("R7 new block hit",    2, 1'b0, 8'h30, 16'h0,    1, 16'h6666);
        op_chk("R3 write miss inv",   0, 1'b1, 8'h11, 16'h7777, 3, -1);
        op_chk("R3 sharer lost copy", 3, 1'b0, 8'h11, 16'h0,    3, 16'h7777);
        op_chk("R6 read from owner",  1, 1'b0, 8'h30, 16'h0,    3, 16'h6666);
        op_chk("R6 owner downgraded", 2, 1'b1, 8'h30, 16'h8888, 3, -1);

        // R12 pseudo-random sweep over 16 conflicting addresses on lines 0 and 1
        begin
            logic [15:0] lfsr;
            lfsr = 16'hACE1;
            for (int s = 0; s < 800; s++) begin
                logic [AW-1:0] a;
                logic [DW-1:0] rd;
                int lat;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                a = 8'h10 + 8'(lfsr[4:3]) * 8'h20 + 8'(lfsr[2]) + (8'(lfsr[6]) << 1);
                do_op(int'(lfsr[1:0]), lfsr[5], a, lfsr ^ 16'h5A3C, rd, lat);
                if (!lfsr[5]) check("R12 sweep load", int'(rd), int'(ref_mem[a]));
            end
            for (int c = 0; c < NC; c++)
                for (int k = 0; k < 16; k++) begin
                    logic [AW-1:0] a;
                    logic [DW-1:0] rd;
                    int lat;
                    a = 8'h10 + 8'(k[3:2]) * 8'h20 + 8'(k[0]) + (8'(k[1]) << 1);
                    do_op(c, 1'b0, a, 16'h0, rd, lat);
                    check("R12 final load", int'(rd), int'(ref_mem[a]));
                end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule